// File: doc/BRIEF.md
# DMA Register File and Interrupt Aggregator

This block is the memory-mapped register interface of a multi-channel DMA engine. It covers a 4 KB address window with 32-bit word accesses. It holds the global configuration and sync words. It also holds one bank per channel with five words: source, destination, link, control and configuration. It presents read-only status views, a bitmap of the enabled channels and a set of identification bytes.

The transfer datapath sits outside this block. It sees every channel register on flat output buses. It receives a one-cycle kick whenever software writes a configuration word. It reports completion and failure back through per-channel set pulses. The block keeps raw terminal-count and error bits for each channel. It gates these bits with masks taken from each channel's own configuration word, so no separate mask registers exist. From the gated bits it drives three interrupt lines.

Reads are combinational from the address. Writes take effect on the rising clock edge while the write strobe is high.

Top module: `dma_regfile`

## Requirements
- R1: After reset, every readable register returns zero except the identification bytes, and all three interrupt outputs are low.
- R2: A channel register sits at address 0x100 + 32*channel + 4*word. Words 0 to 4 are source, destination, link, control and configuration, and each reads back the last value written. Words 5 to 7 of a bank read as zero and ignore writes.
- R3: An access to a channel bank whose index (address bits [7:5]) is at or above the channel count reads as zero and ignores writes.
- R4: Raw terminal-count (read at 0x14) and raw error (read at 0x18) hold one bit per channel. A set pulse on a channel sets its bit. Writing 0x08 (terminal-count) or 0x10 (error) clears each bit where the written data has a 1. When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: A channel's terminal-count mask is bit 15 of its configuration, and its error mask is bit 14. Offset 0x04 reads raw terminal-count AND mask, 0x0C reads raw error AND mask, and 0x00 reads the OR of the two.
- R6: irq_tc is high when any masked terminal-count bit is set, and irq_err is high when any masked error bit is set. irq_any is their OR.
- R7: Offset 0x1C reads one bit per channel, equal to bit 0 of that channel's configuration.
- R8: Word k of 0xFE0 to 0xFFC reads identification byte k. The bytes are 0x80 (eight channels) or 0x81 (any other count), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05 and 0xB1.
- R9: The software request words 0x20 to 0x2C, the clear words 0x08 and 0x10, and every undecoded offset read as zero. Writes to the software request words and to undecoded offsets change no state.
- R10: kick is high for exactly the one cycle after each write to a channel configuration word or to the global configuration word, and low otherwise.
- R11: The global configuration (0x30) and sync (0x34) words are 32-bit read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte address within the window |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| tc_set | input | NCH | Per-channel terminal-count set pulses |
| err_set | input | NCH | Per-channel error set pulses |
| ch_src | output | NCH*32 | Source words, channel 0 in the low bits |
| ch_dst | output | NCH*32 | Destination words |
| ch_link | output | NCH*32 | Link words |
| ch_ctrl | output | NCH*32 | Control words |
| ch_conf | output | NCH*32 | Configuration words |
| glb_conf | output | 32 | Global configuration word |
| kick | output | 1 | Pulse after a configuration write |
| irq_tc | output | 1 | Masked terminal-count interrupt |
| irq_err | output | 1 | Masked error interrupt |
| irq_any | output | 1 | OR of the two interrupts |

## Verification
Several properties are checked on every cycle. A set pulse always lands in its raw bit, even against a clear in the same cycle. A raw bit never rises without a pulse. A clear with no competing pulse empties the cleared bits. A kick always follows a write. A terminal-count interrupt never appears without a raw bit behind it.

The decode map needs the bench's scenarios. This covers bank stride, unimplemented channel indices, the holes, the identification bytes and the masked views. It also covers which writes produce a kick. Random accesses are compared against a bench model of the register map, and directed cases cover reset and a set colliding with a clear.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NCH-1:0]    tc_set,
  input  logic [NCH-1:0]    err_set,
  output logic [NCH*32-1:0] ch_src,
  output logic [NCH*32-1:0] ch_dst,
  output logic [NCH*32-1:0] ch_link,
  output logic [NCH*32-1:0] ch_ctrl,
  output logic [NCH*32-1:0] ch_conf,
  output logic [31:0]       glb_conf,
  output logic              kick,
  output logic              irq_tc,
  output logic              irq_err,
  output logic              irq_any
);

  localparam logic [3:0] NCH_L = 4'(NCH);
  localparam logic [7:0] ID0   = (NCH == 8) ? 8'h80 : 8'h81;

  logic [31:0] src_q  [NCH];
  logic [31:0] dst_q  [NCH];
  logic [31:0] link_q [NCH];
  logic [31:0] ctrl_q [NCH];
  logic [31:0] conf_q [NCH];
  logic [31:0] sync_q;
  logic [NCH-1:0] raw_tc, raw_err, tc_mask, err_mask, ch_en;

  wire        unused_lsb = ^addr[1:0];
  wire [9:0]  gw     = addr[11:2];
  wire [2:0]  ch_idx = addr[7:5];
  wire [2:0]  wsel   = addr[4:2];
  wire        in_ch  = (addr[11:8] == 4'h1);
  wire        in_id  = (addr[11:5] == 7'h7F);
  wire        ch_ok  = in_ch && ({1'b0, ch_idx} < NCH_L) && (wsel <= 3'd4);

  wire wr_ch    = wr_en && ch_ok;
  wire clr_tc   = wr_en && (gw == 10'd2);
  wire clr_err  = wr_en && (gw == 10'd4);
  wire wr_gconf = wr_en && (gw == 10'd12);
  wire wr_sync  = wr_en && (gw == 10'd13);

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      wire sel = wr_ch && (ch_idx == 3'(c));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          src_q[c]  <= '0;
          dst_q[c]  <= '0;
          link_q[c] <= '0;
          ctrl_q[c] <= '0;
          conf_q[c] <= '0;
        end else if (sel) begin
          case (wsel)
            3'd0:    src_q[c]  <= wdata;
            3'd1:    dst_q[c]  <= wdata;
            3'd2:    link_q[c] <= wdata;
            3'd3:    ctrl_q[c] <= wdata;
            default: conf_q[c] <= wdata;
          endcase
        end
      end
      assign tc_mask[c]  = conf_q[c][15];
      assign err_mask[c] = conf_q[c][14];
      assign ch_en[c]    = conf_q[c][0];
      assign ch_src [c*32 +: 32] = src_q[c];
      assign ch_dst [c*32 +: 32] = dst_q[c];
      assign ch_link[c*32 +: 32] = link_q[c];
      assign ch_ctrl[c*32 +: 32] = ctrl_q[c];
      assign ch_conf[c*32 +: 32] = conf_q[c];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_tc   <= '0;
      raw_err  <= '0;
      glb_conf <= '0;
      sync_q   <= '0;
      kick     <= 1'b0;
    end else begin
      raw_tc  <= (raw_tc  & ~(clr_tc  ? wdata[NCH-1:0] : '0)) | tc_set;
      raw_err <= (raw_err & ~(clr_err ? wdata[NCH-1:0] : '0)) | err_set;
      if (wr_gconf) glb_conf <= wdata;
      if (wr_sync)  sync_q   <= wdata;
      kick <= wr_gconf || (wr_ch && wsel == 3'd4);
    end
  end

  wire [NCH-1:0] tc_v  = raw_tc  & tc_mask;
  wire [NCH-1:0] err_v = raw_err & err_mask;

  assign irq_tc  = |tc_v;
  assign irq_err = |err_v;
  assign irq_any = irq_tc | irq_err;

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0:    id_byte = ID0;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h0A;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_comb begin
    rdata = '0;
    if (in_id) begin
      rdata = {24'h0, id_byte(wsel)};
    end else if (in_ch) begin
      if (ch_ok) begin
        case (wsel)
          3'd0:    rdata = src_q[ch_idx];
          3'd1:    rdata = dst_q[ch_idx];
          3'd2:    rdata = link_q[ch_idx];
          3'd3:    rdata = ctrl_q[ch_idx];
          default: rdata = conf_q[ch_idx];
        endcase
      end
    end else begin
      case (gw)
        10'd0:   rdata = 32'(tc_v | err_v);
        10'd1:   rdata = 32'(tc_v);
        10'd3:   rdata = 32'(err_v);
        10'd5:   rdata = 32'(raw_tc);
        10'd6:   rdata = 32'(raw_err);
        10'd7:   rdata = 32'(ch_en);
        10'd12:  rdata = glb_conf;
        10'd13:  rdata = sync_q;
        default: rdata = '0;
      endcase
    end
  end

  AST_TC_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_set) |=> ((raw_tc & $past(tc_set)) == $past(tc_set))); // R4
  AST_ERR_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ((raw_err & $past(err_set)) == $past(err_set))); // R4
  AST_NO_SPURIOUS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((raw_tc & ~$past(raw_tc) & ~$past(tc_set)) == '0)); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tc && tc_set == '0) |=> ((raw_tc & $past(wdata[NCH-1:0])) == '0)); // R4
  AST_KICK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (kick |-> $past(wr_en))); // R10
  AST_TC_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tc |-> (raw_tc != '0)); // R6

endmodule

// File: tb/test_dma_regfile.sv
module test_dma_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] tc_set = '0, err_set = '0;
  logic [NCH*32-1:0] ch_src, ch_dst, ch_link, ch_ctrl, ch_conf;
  logic [31:0] glb_conf;
  logic kick, irq_tc, irq_err, irq_any;

  int checks = 0, fails = 0;

  logic [31:0] m_reg [8][5];
  logic [31:0] m_gconf, m_sync;
  logic [NCH-1:0] m_tc, m_er;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regfile #(.NCH(NCH)) i_dma_regfile (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .tc_set(tc_set), .err_set(err_set), .ch_src(ch_src),
    .ch_dst(ch_dst), .ch_link(ch_link), .ch_ctrl(ch_ctrl), .ch_conf(ch_conf),
    .glb_conf(glb_conf), .kick(kick), .irq_tc(irq_tc), .irq_err(irq_err),
    .irq_any(irq_any));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (addr %h)", tag, act, exp, addr);
    end
  endtask

  function automatic logic [NCH-1:0] mtc();
    logic [NCH-1:0] m;
    for (int c = 0; c < NCH; c++) m[c] = m_reg[c][4][15];
    return m;
  endfunction

  function automatic logic [NCH-1:0] mer();
    logic [NCH-1:0] m;
    for (int c = 0; c < NCH; c++) m[c] = m_reg[c][4][14];
    return m;
  endfunction

  function automatic logic [NCH-1:0] men();
    logic [NCH-1:0] m;
    for (int c = 0; c < NCH; c++) m[c] = m_reg[c][4][0];
    return m;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [7:0] ids [8];
    ids = '{8'h81, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (a >= 12'hFE0) return {24'h0, ids[a[4:2]]};
    if (a[11:8] == 4'h1) begin
      if (int'(a[7:5]) >= NCH || a[4:2] > 3'd4) return 32'h0;
      return m_reg[a[7:5]][a[4:2]];
    end
    case (a[11:2])
      10'd0:  return 32'((m_tc & mtc()) | (m_er & mer()));
      10'd1:  return 32'(m_tc & mtc());
      10'd3:  return 32'(m_er & mer());
      10'd5:  return 32'(m_tc);
      10'd6:  return 32'(m_er);
      10'd7:  return 32'(men());
      10'd12: return m_gconf;
      10'd13: return m_sync;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    if (a >= 12'hFE0) return "R8";
    if (a[11:8] == 4'h1) return (int'(a[7:5]) >= NCH) ? "R3" : "R2";
    case (a[11:2])
      10'd0, 10'd1, 10'd3: return "R5";
      10'd5, 10'd6:        return "R4";
      10'd7:               return "R7";
      10'd12, 10'd13:      return "R11";
      default:             return "R9";
    endcase
  endfunction

  task automatic rd(input logic [11:0] a, input string tag);
    addr = a;
    #1;
    check(tag, rdata, exp_rd(a));
  endtask

  task automatic check_irq();
    check("R6 irq_tc", 32'(irq_tc), 32'(|(m_tc & mtc())));
    check("R6 irq_err", 32'(irq_err), 32'(|(m_er & mer())));
    check("R6 irq_any", 32'(irq_any), 32'(|(m_tc & mtc()) || |(m_er & mer())));
  endtask

  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic [NCH-1:0] ts, input logic [NCH-1:0] es);
    logic ek;
    ek = 1'b0;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; tc_set = ts; err_set = es;
    @(negedge clk);
    wr_en = 1'b0; tc_set = '0; err_set = '0;
    if (we) begin
      if (a[11:8] == 4'h1) begin
        if (int'(a[7:5]) < NCH && a[4:2] <= 3'd4) begin
          m_reg[a[7:5]][a[4:2]] = d;
          ek = (a[4:2] == 3'd4);
        end
      end else if (a[11:2] == 10'd2) m_tc = m_tc & ~d[NCH-1:0];
      else if (a[11:2] == 10'd4) m_er = m_er & ~d[NCH-1:0];
      else if (a[11:2] == 10'd12) begin m_gconf = d; ek = 1'b1; end
      else if (a[11:2] == 10'd13) m_sync = d;
    end
    m_tc = m_tc | ts;
    m_er = m_er | es;
    check("R10 kick", 32'(kick), 32'(ek));
    check_irq();
  endtask

  function automatic logic [11:0] pick_addr();
    case ($urandom % 5)
      0, 1: return 12'h100 | 12'(($urandom % 4) << 5) | 12'(($urandom % 8) << 2);
      2:    return 12'(($urandom % 16) << 2);
      3:    return 12'hFE0 + 12'(($urandom % 8) << 2);
      default: return 12'($urandom) & 12'hFFC;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 8; c++) for (int w = 0; w < 5; w++) m_reg[c][w] = '0;
    m_gconf = '0; m_sync = '0; m_tc = '0; m_er = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 16; a++) rd(12'(a << 2), "R1");
    for (int a = 0; a < 10; a++) rd(12'h100 + 12'(a << 2), "R1");
    for (int a = 0; a < 8; a++) rd(12'hFE0 + 12'(a << 2), "R1");
    check_irq();

    // R2 stride and R10 kick
    step(1, 12'h124, 32'hDEAD_0001, '0, '0);
    rd(12'h124, "R2");
    rd(12'h104, "R2");
    step(1, 12'h130, 32'h0000_C001, '0, '0);
    rd(12'h01C, "R7");
    // R3: channel index out of range ignored
    step(1, 12'h150, 32'hFFFF_FFFF, '0, '0);
    rd(12'h150, "R3");
    rd(12'h01C, "R7");
    // R9: software request write ignored, word 5 ignored
    step(1, 12'h024, 32'hFFFF_FFFF, '0, '0);
    rd(12'h024, "R9");
    step(1, 12'h134, 32'h1234_5678, '0, '0);
    rd(12'h134, "R9");
    rd(12'h130, "R2");
    // R4 set pulses then set-wins collision
    step(0, 12'h0, 32'h0, 2'b11, 2'b10);
    rd(12'h014, "R4");
    rd(12'h000, "R5");
    step(1, 12'h008, 32'h3, 2'b01, '0);
    rd(12'h014, "R4");
    check("R4 set wins", rdata, 32'h1);
    step(1, 12'h010, 32'h3, '0, '0);
    rd(12'h018, "R4");
    // R11
    step(1, 12'h030, 32'hA5A5_0001, '0, '0);
    rd(12'h030, "R11");
    step(1, 12'h034, 32'h0F0F_1234, '0, '0);
    rd(12'h034, "R11");

    for (int i = 0; i < 1500; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = pick_addr();
      d = $urandom;
      if ($urandom % 3 == 0) d = d & 32'h0000_C001;
      step(($urandom % 4) != 0, a, d, NCH'($urandom), NCH'($urandom % 2 ? 0 : $urandom));
      rd(a, tag_of(a));
      a = pick_addr();
      rd(a, tag_of(a));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule